// File: doc/BRIEF.md
# T1 Bit-Oriented Code Detector

This block watches the received facility data link (FDL) bit stream of a T1 line running in extended superframe (ESF) mode. It looks for repeated bit-oriented codewords, each carrying a 6-bit message. Once the same message has arrived in enough back-to-back codewords, it latches the value and raises a detect flag. When no valid codeword has arrived for a programmable number of data link bits, it raises a clear flag.

Frame alignment is done upstream. An aligner supplies each data link bit together with a one-cycle strobe. Software reads the latched code and the two flags, and acknowledges each flag by writing 1 to it. A single interrupt line combines the two flags through their own enable bits.

A detect flag that software has acknowledged stays low while the same message keeps arriving. It rises again only for a different message, or for the same message after a clear event has occurred.

Top module: `t1_boc_detector`

## Requirements
- R1: After reset `code_q` is 0, and `det_flag`, `clr_flag` and `irq` are all 0.
- R2: A codeword is sixteen data link bits in arrival order: eight 1s, one 0, the six message bits with bit 0 first, then one 0. On a qualifying detection, `code_q` takes the message. `code_q` changes at no other time.
- R3: `filt_sel` value F requires 2F+1 back-to-back codewords carrying the same message (1, 3, 5 or 7). `det_flag` is 1 in the cycle after the strobe that delivers the final bit of the codeword that completes that run.
- R4: A codeword carrying a different message restarts the run count. So does any break of more than zero bits between codewords.
- R5: After `det_flag` is acknowledged, further codewords with the already-latched message do not set it again. A qualifying run of a different message sets it again and updates `code_q`.
- R6: After a clear event, a qualifying run of the same message as `code_q` sets `det_flag` again.
- R7: `disint_sel` value D sets `clr_flag` when 16<<D data link bits (16, 32, 64 or 128) have arrived since the last valid codeword. A clear event happens once per stretch of absence, and only if a valid codeword was seen before that stretch.
- R8: Writing 1 to `det_w1c` or `clr_w1c` clears the matching flag in the next cycle. If a set condition for that flag occurs in the same cycle, the flag stays set.
- R9: `irq` is 1 exactly when (`det_flag` and `det_mask_en`) or (`clr_flag` and `clr_mask_en`).
- R10: While `esf_en` is 0, strobes are ignored: no bit is taken in, neither flag is set, and `code_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_en | input | 1 | High when the line runs in ESF mode |
| fdl_stb | input | 1 | One-cycle strobe marking a data link bit |
| fdl_bit | input | 1 | Data link bit, valid with the strobe |
| filt_sel | input | 2 | Selects the run length needed for detection |
| disint_sel | input | 2 | Selects the absence length needed for clear |
| det_w1c | input | 1 | Write-1 pulse clearing the detect flag |
| clr_w1c | input | 1 | Write-1 pulse clearing the clear flag |
| det_mask_en | input | 1 | Lets the detect flag reach the interrupt |
| clr_mask_en | input | 1 | Lets the clear flag reach the interrupt |
| code_q | output | 6 | Last detected message |
| det_flag | output | 1 | Latched detect status |
| clr_flag | output | 1 | Latched clear status |
| irq | output | 1 | Combined, masked interrupt |

## Verification
The assertions assume that `fdl_stb` marks one bit per pulse and that `filt_sel` and `disint_sel` stay fixed while a run or an absence is being counted. The acknowledge pulses are assumed to be single-cycle writes. The stimulus programs the two settings only between sequences, while no strobe is active. It drives every strobe as a one-cycle pulse followed by an idle cycle, and raises an acknowledge pulse together with a strobe only in the deliberate set-wins case.

// File: rtl/t1_boc_detector.sv
module t1_boc_detector #(
  parameter int CODE_W = 6,
  parameter int RUN_W  = 3,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              esf_en,
  input  logic              fdl_stb,
  input  logic              fdl_bit,
  input  logic [1:0]        filt_sel,
  input  logic [1:0]        disint_sel,
  input  logic              det_w1c,
  input  logic              clr_w1c,
  input  logic              det_mask_en,
  input  logic              clr_mask_en,
  output logic [CODE_W-1:0] code_q,
  output logic              det_flag,
  output logic              clr_flag,
  output logic              irq
);
  localparam int CW_LEN = 2 * CODE_W + 4;
  localparam int FLAG_W = CW_LEN - CODE_W - 2;
  localparam logic [GAP_W-1:0] GAP_SPAN = GAP_W'(CW_LEN - 1);
  localparam logic [GAP_W-1:0] GAP_BASE = GAP_W'(CW_LEN);
  localparam logic [RUN_W-1:0] RUN_MAX  = '1;

  logic [CW_LEN-1:0] sr;
  logic [CODE_W-1:0] last_code;
  logic [RUN_W-1:0]  run;
  logic [GAP_W-1:0]  gap;
  logic              held, present;

  wire              adv   = esf_en & fdl_stb;
  wire [CW_LEN-1:0] sr_nx = {sr[CW_LEN-2:0], fdl_bit};
  wire              hit   = adv && (&sr_nx[CW_LEN-1:CODE_W+2]) && !sr_nx[CODE_W+1] && !sr_nx[0];

  logic [CODE_W-1:0] rx_code;
  always_comb
    for (int i = 0; i < CODE_W; i++) rx_code[i] = sr_nx[CODE_W - i];

  wire              same   = (rx_code == last_code) && (gap == GAP_SPAN);
  wire [RUN_W-1:0]  run_nx = !same ? RUN_W'(1) : (run == RUN_MAX ? run : run + 1'b1);
  wire [RUN_W-1:0]  need   = {filt_sel, 1'b1};
  wire              det_ev = hit && (run_nx == need) && (!held || rx_code != code_q);
  wire [GAP_W-1:0]  lim    = GAP_BASE << disint_sel;
  wire [GAP_W-1:0]  gap_nx = (&gap) ? gap : gap + 1'b1;
  wire              clr_ev = adv && !hit && present && (gap_nx == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; last_code <= '0; run <= '0; gap <= '1;
      held <= 1'b0; present <= 1'b0; code_q <= '0;
      det_flag <= 1'b0; clr_flag <= 1'b0;
    end else begin
      if (adv) begin
        sr <= sr_nx;
        if (hit) begin
          last_code <= rx_code;
          run       <= run_nx;
          gap       <= '0;
          present   <= 1'b1;
        end else begin
          gap <= gap_nx;
        end
      end
      if (clr_ev) begin
        present <= 1'b0;
        held    <= 1'b0;
      end
      if (det_ev) begin
        held   <= 1'b1;
        code_q <= rx_code;
      end
      det_flag <= det_ev | (det_flag & ~det_w1c);
      clr_flag <= clr_ev | (clr_flag & ~clr_w1c);
    end
  end

  assign irq = (det_flag & det_mask_en) | (clr_flag & clr_mask_en);

  // R2
  code_only_on_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> det_flag);
  // R3
  det_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> $past(fdl_stb));
  // R7
  clr_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_flag) |-> $past(fdl_stb));
  // R8
  det_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_w1c && !fdl_stb) |=> !det_flag);
  // R8
  clr_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w1c && !fdl_stb) |=> !clr_flag);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_flag && !clr_flag) |-> !irq);
  // R10
  esf_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !esf_en |=> ($stable(code_q) && !$rose(det_flag) && !$rose(clr_flag)));
endmodule

// File: tb/sim_t1_boc_detector.sv
`timescale 1ns/1ps
module sim_t1_boc_detector;
  logic clk = 1'b0;
  logic rst_n, esf_en, fdl_stb, fdl_bit, det_w1c, clr_w1c, det_mask_en, clr_mask_en;
  logic [1:0] filt_sel, disint_sel;
  logic [5:0] code_q;
  logic det_flag, clr_flag, irq;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  t1_boc_detector u0 (.clk, .rst_n, .esf_en, .fdl_stb, .fdl_bit, .filt_sel, .disint_sel,
    .det_w1c, .clr_w1c, .det_mask_en, .clr_mask_en, .code_q, .det_flag, .clr_flag, .irq);

  // {filt(2), code(6), codewords(3), expected det(1)}
  localparam logic [11:0] VEC [0:7] = '{
    {2'd0, 6'h05, 3'd1, 1'b1}, {2'd1, 6'h2A, 3'd2, 1'b0},
    {2'd1, 6'h2A, 3'd3, 1'b1}, {2'd2, 6'h11, 3'd4, 1'b0},
    {2'd2, 6'h11, 3'd5, 1'b1}, {2'd3, 6'h3F, 3'd6, 1'b0},
    {2'd3, 6'h3F, 3'd7, 1'b1}, {2'd0, 6'h00, 3'd1, 1'b1}};

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; esf_en = 1'b1; fdl_stb = 1'b0; fdl_bit = 1'b1;
    det_w1c = 1'b0; clr_w1c = 1'b0; det_mask_en = 1'b0; clr_mask_en = 1'b0;
    filt_sel = 2'd0; disint_sel = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic wd);
    @(negedge clk);
    fdl_stb = 1'b1; fdl_bit = b; det_w1c = wd;
    @(negedge clk);
    fdl_stb = 1'b0; det_w1c = 1'b0;
  endtask

  task automatic send_cw(input logic [5:0] c, input logic wd_last);
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) send_bit(c[i], 1'b0);
    send_bit(1'b0, wd_last);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0);
  endtask

  task automatic ack_det();
    @(negedge clk); det_w1c = 1'b1;
    @(negedge clk); det_w1c = 1'b0;
  endtask

  task automatic ack_clr();
    @(negedge clk); clr_w1c = 1'b1;
    @(negedge clk); clr_w1c = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    check("R1 code", 8'(code_q), 8'h00);
    check("R1 det", 8'(det_flag), 8'h0);
    check("R1 clr", 8'(clr_flag), 8'h0);
    check("R1 irq", 8'(irq), 8'h0);

    // R2 R3: run length per filter setting
    for (int v = 0; v < 8; v++) begin
      do_reset();
      filt_sel = VEC[v][11:10];
      for (int k = 0; k < int'(VEC[v][3:1]); k++) send_cw(VEC[v][9:4], 1'b0);
      check("R3 det", 8'(det_flag), 8'(VEC[v][0]));
      if (VEC[v][0]) check("R2 code", 8'(code_q), 8'(VEC[v][9:4]));
    end

    // R4: different code and gap restart the run
    do_reset();
    filt_sel = 2'd1;
    send_cw(6'h0C, 1'b0); send_cw(6'h0C, 1'b0); send_cw(6'h21, 1'b0);
    send_cw(6'h0C, 1'b0); send_cw(6'h0C, 1'b0);
    check("R4 other code restarts", 8'(det_flag), 8'h0);
    send_cw(6'h0C, 1'b0);
    check("R4 third in run", 8'(det_flag), 8'h1);
    check("R4 code", 8'(code_q), 8'h0C);
    do_reset();
    filt_sel = 2'd1;
    send_cw(6'h1B, 1'b0); send_cw(6'h1B, 1'b0); send_idle(8); send_cw(6'h1B, 1'b0);
    check("R4 gap restarts", 8'(det_flag), 8'h0);
    send_cw(6'h1B, 1'b0); send_cw(6'h1B, 1'b0);
    check("R4 run after gap", 8'(det_flag), 8'h1);

    // R5 R6 R7 (disintegration 16 bits)
    do_reset();
    disint_sel = 2'd0;
    send_cw(6'h33, 1'b0);
    check("R5 first det", 8'(det_flag), 8'h1);
    ack_det();
    check("R8 w1c det", 8'(det_flag), 8'h0);
    send_cw(6'h33, 1'b0); send_cw(6'h33, 1'b0);
    check("R5 same code stays clear", 8'(det_flag), 8'h0);
    send_cw(6'h12, 1'b0);
    check("R5 new code", 8'(det_flag), 8'h1);
    check("R5 new code value", 8'(code_q), 8'h12);
    ack_det();
    send_idle(15);
    check("R7 before limit", 8'(clr_flag), 8'h0);
    send_idle(1);
    check("R7 at limit 16", 8'(clr_flag), 8'h1);
    send_cw(6'h12, 1'b0);
    check("R6 same code after clear", 8'(det_flag), 8'h1);
    ack_clr();
    check("R8 w1c clr", 8'(clr_flag), 8'h0);
    ack_det();
    send_idle(40); ack_clr(); send_idle(40);
    check("R7 single clear event", 8'(clr_flag), 8'h0);

    // R7 longest disintegration
    do_reset();
    disint_sel = 2'd3;
    send_cw(6'h01, 1'b0);
    send_idle(127);
    check("R7 127 bits", 8'(clr_flag), 8'h0);
    send_idle(1);
    check("R7 128 bits", 8'(clr_flag), 8'h1);
    do_reset();
    send_idle(200);
    check("R7 no clear without code", 8'(clr_flag), 8'h0);

    // R8 set wins
    do_reset();
    send_cw(6'h07, 1'b0);
    send_cw(6'h38, 1'b1);
    check("R8 set wins", 8'(det_flag), 8'h1);
    check("R8 code", 8'(code_q), 8'h38);

    // R9 masking
    check("R9 masked off", 8'(irq), 8'h0);
    @(negedge clk); det_mask_en = 1'b1; #1;
    check("R9 det enabled", 8'(irq), 8'h1);
    ack_det(); #1;
    check("R9 det cleared", 8'(irq), 8'h0);
    disint_sel = 2'd0; clr_mask_en = 1'b1;
    send_cw(6'h38, 1'b0); ack_det(); send_idle(16);
    check("R9 clr enabled", 8'(irq), 8'h1);
    @(negedge clk); clr_mask_en = 1'b0; #1;
    check("R9 clr masked", 8'(irq), 8'h0);

    // R10 ESF off
    do_reset();
    send_cw(6'h2D, 1'b0); ack_det();
    esf_en = 1'b0;
    send_cw(6'h15, 1'b0); send_cw(6'h15, 1'b0); send_idle(200);
    check("R10 det ignored", 8'(det_flag), 8'h0);
    check("R10 code held", 8'(code_q), 8'h2D);
    check("R10 clr ignored", 8'(clr_flag), 8'h0);

    summary();
    $finish;
  end
endmodule